// File: doc/BRIEF.md
# Whole-Register and Mask Vector Load Sequencer

This block carries out the two vector load kinds that do not depend on the current element type or grouping settings. The first is a whole-register load, which copies a run of complete vector registers from memory. The second is a mask load, which copies only as many bytes as the active vector length needs. The block talks to memory through a simple request/response port that is one beat wide. It writes each returned beat into a register-file write port that is one vector register (VLENB bytes) wide, with a per-byte enable.

A decode stage checks legality before it pulses `start`. It also supplies a base address, the first destination register, the register count (1, 2, 4 or 8, aligned) and the current vector length. When the load finishes, the block pulses `done` together with the two side outputs. One side output marks the vector state dirty. The other clears the restart index. If memory reports a fault, the block pulses `fault` instead and returns the address of the failing beat. The side outputs then fire only if at least one register had already been overwritten.

Top module: `vreg_bulk_loader`

## Requirements
- R1: A whole-register load issues one request per register i = 0..nreg-1 at address base + i*VLENB, in ascending order. Each request has `mreq_nbytes` = VLENB and stays asserted with a stable address until its response arrives. The returned beat is written to register vd + i with all byte enables set.
- R2: A whole-register load ignores `vl`. Its requests and register writes are the same whatever value `vl` holds.
- R3: A mask load with `kind_mask`=1 and `vl` > 0 issues a single request at the base address with `mreq_nbytes` = ceil(vl/8). It writes the returned bytes into bytes 0 upward of register vd.
- R4: During a mask load, bytes of vd at index ceil(vl/8) and above keep their old value. The byte enables are a contiguous run starting at byte 0.
- R5: A mask load with `vl` = 0 issues no memory request. On the next cycle it pulses `done`, `mark_dirty` and `clear_vstart`.
- R6: When a load completes without a fault, `done`, `mark_dirty` and `clear_vstart` pulse together for exactly one cycle, and `fault` stays low.
- R7: A fault on register i > 0 pulses `fault`, `mark_dirty` and `clear_vstart` together, with `fault_addr` set to the failing beat address. Registers before i keep their new data, no further request is made, and `done` stays low.
- R8: A fault on the first beat (i = 0, or a mask load) pulses `fault` only. No register is written, and `mark_dirty` and `clear_vstart` stay low.
- R9: After reset the block is idle. `busy`, `mreq_valid`, `wr_en`, `done`, `fault`, `mark_dirty` and `clear_vstart` are all low.
- R10: A `start` pulse while `busy` is high is ignored. The running load completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a load (taken only when idle) |
| kind_mask | input | 1 | 1 = mask load, 0 = whole-register load |
| base_addr | input | ADDR_W | Byte address of the first beat |
| vd | input | 5 | First destination register |
| nreg | input | 4 | Register count for a whole-register load (1, 2, 4, 8) |
| vl | input | VL_W | Current vector length, used by mask loads |
| busy | output | 1 | A load is in progress |
| mreq_valid | output | 1 | Memory read request, held until response |
| mreq_addr | output | ADDR_W | Request byte address |
| mreq_nbytes | output | LOG2(VLENB)+1 | Bytes requested |
| mrsp_valid | input | 1 | Response strobe |
| mrsp_fault | input | 1 | Response carries an access fault |
| mrsp_data | input | 8*VLENB | Response bytes, byte 0 in the low bits |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 5 | Register written |
| wr_be | output | VLENB | Byte enables of the write |
| wr_data | output | 8*VLENB | Write data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_addr | output | ADDR_W | Address of the failing beat |
| mark_dirty | output | 1 | Pulse: vector state becomes dirty |
| clear_vstart | output | 1 | Pulse: restart index returns to zero |

## Verification
The assertions assume that memory answers only while a request is pending, and that decode supplies an aligned destination with nreg of 1, 2, 4 or 8, so vd + nreg never passes register 31. The stimulus draws nreg from that set and rounds vd down to a multiple of nreg. Its memory model replies after a random delay, and only to a raised request. It places faults only on addresses that the load will actually request. Directed cases cover vl of 0, 1, 8, 9 and the maximum, faults on the first and on a later beat, and a second start pulse during a busy load.

// File: rtl/vbl_pkg.sv
// Shared types for the bulk vector load sequencer.
package vbl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } vbl_state_e;

    typedef enum logic [0:0] {
        LD_WHOLE = 1'b0,
        LD_MASK  = 1'b1
    } vbl_kind_e;
endpackage

// File: rtl/vbl_beat_ctr.sv
// Beat counter and address generator.
// Counts the register index within a load and forms the beat address
// (base + idx * VLENB) and the destination register (vd + idx).
// Assumes VLENB is a power of two and vd + nreg - 1 fits in 5 bits.
module vbl_beat_ctr #(
    parameter int VLENB  = 16,
    parameter int ADDR_W = 32,
    parameter int NREG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [NREG_W-1:0] count,
    input  logic [ADDR_W-1:0] base,
    input  logic [4:0]        first_reg,
    output logic [NREG_W-1:0] idx,
    output logic              last,
    output logic [ADDR_W-1:0] addr,
    output logic [4:0]        reg_idx
);
    localparam int LOG_B = $clog2(VLENB);

    // Beat index register: cleared at load start, stepped after each good beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

    // Final-beat flag, beat address and destination register.
    always_comb begin
        last    = (idx == count - 1'b1);
        addr    = base + (ADDR_W'(idx) << LOG_B);
        reg_idx = first_reg + 5'(idx);
    end
endmodule

// File: rtl/vbl_mask_span.sv
// Mask-load span calculator.
// Converts a vector length in bits into a byte count ceil(vl/8) and a
// contiguous byte-enable vector covering bytes 0 .. count-1.
// Assumes vl never exceeds VLENB*8.
module vbl_mask_span #(
    parameter int VLENB = 16
) (
    input  logic [$clog2(VLENB*8):0] vl,
    output logic [$clog2(VLENB):0]   nbytes,
    output logic [VLENB-1:0]         be
);
    localparam int VL_W = $clog2(VLENB*8) + 1;
    localparam int NB_W = $clog2(VLENB) + 1;

    logic [VL_W:0] rounded;

    // Round the bit count up to whole bytes.
    always_comb begin
        rounded = ({1'b0, vl} + (VL_W+1)'(7)) >> 3;
        nbytes  = rounded[NB_W-1:0];
    end

    // One enable per byte lane, set below the byte count.
    for (genvar b = 0; b < VLENB; b++) begin : g_lane
        assign be[b] = (NB_W'(b) < nbytes);
    end
endmodule

// File: rtl/vreg_bulk_loader.sv
// Whole-register and mask vector load sequencer.
// Takes one start pulse, walks the required beats over a request/response
// memory port (one outstanding request), writes each good beat into the
// register file, then pulses done or fault with the state side outputs.
// Assumes legality (alignment, nreg in {1,2,4,8}) was checked by decode and
// that memory responds only while mreq_valid is high.
module vreg_bulk_loader
    import vbl_pkg::*;
#(
    parameter int VLENB  = 16,
    parameter int ADDR_W = 32,
    parameter int NREG_W = 4,
    localparam int LOG_B = $clog2(VLENB),
    localparam int NB_W  = LOG_B + 1,
    localparam int VL_W  = $clog2(VLENB*8) + 1,
    localparam int DW    = VLENB * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              kind_mask,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [4:0]        vd,
    input  logic [NREG_W-1:0] nreg,
    input  logic [VL_W-1:0]   vl,
    output logic              busy,
    output logic              mreq_valid,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [NB_W-1:0]   mreq_nbytes,
    input  logic              mrsp_valid,
    input  logic              mrsp_fault,
    input  logic [DW-1:0]     mrsp_data,
    output logic              wr_en,
    output logic [4:0]        wr_idx,
    output logic [VLENB-1:0]  wr_be,
    output logic [DW-1:0]     wr_data,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              mark_dirty,
    output logic              clear_vstart
);
    vbl_state_e        state;
    vbl_kind_e         kind_q;
    logic [ADDR_W-1:0] base_q;
    logic [4:0]        vd_q;
    logic [NREG_W-1:0] nreg_q;
    logic [NB_W-1:0]   nbytes_q;
    logic [VLENB-1:0]  be_q;

    logic              accept;
    logic              rsp_ok;
    logic              rsp_bad;
    logic              final_beat;
    logic [NREG_W-1:0] idx;
    logic              idx_last;
    logic [ADDR_W-1:0] beat_addr;
    logic [4:0]        beat_reg;
    logic [NB_W-1:0]   span_nbytes;
    logic [VLENB-1:0]  span_be;

    vbl_beat_ctr #(
        .VLENB (VLENB),
        .ADDR_W(ADDR_W),
        .NREG_W(NREG_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .advance  (rsp_ok),
        .count    (nreg_q),
        .base     (base_q),
        .first_reg(vd_q),
        .idx      (idx),
        .last     (idx_last),
        .addr     (beat_addr),
        .reg_idx  (beat_reg)
    );

    vbl_mask_span #(
        .VLENB(VLENB)
    ) u_span (
        .vl    (vl),
        .nbytes(span_nbytes),
        .be    (span_be)
    );

    // Decode of start acceptance and response outcome.
    always_comb begin
        accept     = (state == ST_IDLE) && start;
        rsp_ok     = (state == ST_WAIT) && mrsp_valid && !mrsp_fault;
        rsp_bad    = (state == ST_WAIT) && mrsp_valid && mrsp_fault;
        final_beat = (kind_q == LD_MASK) || idx_last;
    end

    // Memory request and register write drive.
    always_comb begin
        busy        = (state != ST_IDLE);
        mreq_valid  = (state == ST_WAIT);
        mreq_addr   = beat_addr;
        mreq_nbytes = (kind_q == LD_MASK) ? nbytes_q : NB_W'(VLENB);
        wr_en       = rsp_ok;
        wr_idx      = beat_reg;
        wr_be       = (kind_q == LD_MASK) ? be_q : '1;
        wr_data     = mrsp_data;
    end

    // Load parameters captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= LD_WHOLE;
            base_q   <= '0;
            vd_q     <= '0;
            nreg_q   <= '0;
            nbytes_q <= '0;
            be_q     <= '0;
        end else if (accept) begin
            kind_q   <= kind_mask ? LD_MASK : LD_WHOLE;
            base_q   <= base_addr;
            vd_q     <= vd;
            nreg_q   <= nreg;
            nbytes_q <= span_nbytes;
            be_q     <= span_be;
        end
    end

    // Sequencer state and one-cycle completion/fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            done         <= 1'b0;
            fault        <= 1'b0;
            fault_addr   <= '0;
            mark_dirty   <= 1'b0;
            clear_vstart <= 1'b0;
        end else begin
            done         <= 1'b0;
            fault        <= 1'b0;
            mark_dirty   <= 1'b0;
            clear_vstart <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (kind_mask && (span_nbytes == '0)) begin
                            done         <= 1'b1;
                            mark_dirty   <= 1'b1;
                            clear_vstart <= 1'b1;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rsp_bad) begin
                        state        <= ST_IDLE;
                        fault        <= 1'b1;
                        fault_addr   <= beat_addr;
                        mark_dirty   <= (idx != '0);
                        clear_vstart <= (idx != '0);
                    end else if (rsp_ok && final_beat) begin
                        state        <= ST_IDLE;
                        done         <= 1'b1;
                        mark_dirty   <= 1'b1;
                        clear_vstart <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vreg_bulk_loader_chk.sv
// Protocol checker for the bulk vector load sequencer, bound to the top.
// Assumes memory responds only to a pending request.
module vreg_bulk_loader_chk #(
    parameter int VLENB  = 16,
    parameter int ADDR_W = 32,
    parameter int VL_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              kind_mask,
    input logic [VL_W-1:0]   vl,
    input logic              busy,
    input logic              mreq_valid,
    input logic [ADDR_W-1:0] mreq_addr,
    input logic              mrsp_valid,
    input logic              wr_en,
    input logic [VLENB-1:0]  wr_be,
    input logic              done,
    input logic              fault,
    input logic              mark_dirty,
    input logic              clear_vstart
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && !mrsp_valid |=> mreq_valid && $stable(mreq_addr)); // R1
    AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (((wr_be + 1'b1) & wr_be) == '0) && wr_be[0]); // R4
    AST_VL0_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && kind_mask && (vl == '0) |=> !mreq_valid && done); // R5
    AST_DONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mark_dirty && clear_vstart && !fault); // R6
    AST_DIRTY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty == clear_vstart); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mreq_valid && !wr_en); // R9
endmodule

bind vreg_bulk_loader vreg_bulk_loader_chk #(
    .VLENB (VLENB),
    .ADDR_W(ADDR_W),
    .VL_W  (VL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .kind_mask   (kind_mask),
    .vl          (vl),
    .busy        (busy),
    .mreq_valid  (mreq_valid),
    .mreq_addr   (mreq_addr),
    .mrsp_valid  (mrsp_valid),
    .wr_en       (wr_en),
    .wr_be       (wr_be),
    .done        (done),
    .fault       (fault),
    .mark_dirty  (mark_dirty),
    .clear_vstart(clear_vstart)
);

// File: tb/vreg_bulk_loader_test.sv
// Self-checking bench: random-latency memory model, register-file model
// fed from the write port, expected results computed per load.
module vreg_bulk_loader_test;
    localparam int VLENB  = 16;
    localparam int ADDR_W = 32;
    localparam int VL_W   = 8;
    localparam int NB_W   = 5;
    localparam int DW     = VLENB * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              kind_mask = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [4:0]        vd = '0;
    logic [3:0]        nreg = 4'd1;
    logic [VL_W-1:0]   vl = '0;
    logic              busy, mreq_valid, wr_en, done, fault, mark_dirty, clear_vstart;
    logic [ADDR_W-1:0] mreq_addr, fault_addr;
    logic [NB_W-1:0]   mreq_nbytes;
    logic              mrsp_valid = 1'b0;
    logic              mrsp_fault = 1'b0;
    logic [DW-1:0]     mrsp_data = '0;
    logic [4:0]        wr_idx;
    logic [VLENB-1:0]  wr_be;
    logic [DW-1:0]     wr_data;

    always #10 clk = ~clk;

    vreg_bulk_loader #(.VLENB(VLENB), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .kind_mask(kind_mask),
        .base_addr(base_addr), .vd(vd), .nreg(nreg), .vl(vl), .busy(busy),
        .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_nbytes(mreq_nbytes),
        .mrsp_valid(mrsp_valid), .mrsp_fault(mrsp_fault), .mrsp_data(mrsp_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be), .wr_data(wr_data),
        .done(done), .fault(fault), .fault_addr(fault_addr),
        .mark_dirty(mark_dirty), .clear_vstart(clear_vstart)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] rf  [32][VLENB];
    logic [7:0] exp_rf [32][VLENB];

    // Memory model controls and observed counters.
    bit                fault_en = 0;
    logic [ADDR_W-1:0] fault_at = '0;
    int n_rsp, n_done, n_fault, n_dirty, n_clr, n_wr;
    logic [ADDR_W-1:0] seen_fault_addr;
    logic [ADDR_W-1:0] rsp_addr [16];
    int                rsp_nb   [16];

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] bg_byte(input int r, input int b);
        return 8'(r * 16 + b) ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Memory responder: replies after a random delay while a request is up.
    initial begin
        int wait_n;
        wait_n = 0;
        forever begin
            @(negedge clk); #1;
            if (mrsp_valid) begin
                mrsp_valid = 1'b0;
                mrsp_fault = 1'b0;
                wait_n = $urandom % 4;
            end else if (mreq_valid) begin
                if (wait_n == 0) begin
                    mrsp_valid = 1'b1;
                    mrsp_fault = fault_en && (mreq_addr == fault_at);
                    for (int b = 0; b < VLENB; b++)
                        mrsp_data[b*8 +: 8] = mem_byte(mreq_addr + ADDR_W'(b));
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // Monitor: samples 1 ns before each rising edge.
    initial begin
        forever begin
            @(negedge clk); #9;
            if (rst_n) begin
                if (mreq_valid && mrsp_valid) begin
                    if (n_rsp < 16) begin
                        rsp_addr[n_rsp] = mreq_addr;
                        rsp_nb[n_rsp]   = int'(mreq_nbytes);
                    end
                    n_rsp++;
                end
                if (wr_en) begin
                    n_wr++;
                    for (int b = 0; b < VLENB; b++)
                        if (wr_be[b]) rf[wr_idx][b] = wr_data[b*8 +: 8];
                end
                if (done) n_done++;
                if (fault) begin
                    n_fault++;
                    seen_fault_addr = fault_addr;
                end
                if (mark_dirty) n_dirty++;
                if (clear_vstart) n_clr++;
            end
        end
    end

    task automatic init_rf();
        for (int r = 0; r < 32; r++)
            for (int b = 0; b < VLENB; b++) begin
                rf[r][b]     = bg_byte(r, b);
                exp_rf[r][b] = bg_byte(r, b);
            end
    endtask

    // Run one load; k_fault < 0 means no fault, else fault on beat k_fault.
    task automatic run_load(input bit is_mask, input logic [ADDR_W-1:0] base,
                            input int dreg, input int cnt, input int vlen,
                            input int k_fault, input bit poke_busy, input string tag);
        int beats, nb, good, tmo;
        n_rsp = 0; n_done = 0; n_fault = 0; n_dirty = 0; n_clr = 0; n_wr = 0;
        nb    = (vlen + 7) / 8;
        beats = is_mask ? (nb > 0 ? 1 : 0) : cnt;
        fault_en = (k_fault >= 0);
        fault_at = base + ADDR_W'(k_fault * VLENB);
        good  = (k_fault >= 0) ? k_fault : beats;
        @(negedge clk); #1;
        kind_mask = is_mask; base_addr = base; vd = 5'(dreg);
        nreg = 4'(cnt); vl = VL_W'(vlen); start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (poke_busy) begin
            @(negedge clk); #1;
            kind_mask = 1'b1; vl = 8'd64; vd = 5'(dreg ^ 1); base_addr = base + 32'h400;
            start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        tmo = 0;
        while (n_done == 0 && n_fault == 0 && tmo < 200) begin
            @(negedge clk); tmo++;
        end
        repeat (3) @(negedge clk);
        // Expected register contents.
        for (int i = 0; i < good; i++)
            for (int b = 0; b < VLENB; b++)
                if (!is_mask || b < nb)
                    exp_rf[dreg + i][b] = mem_byte(base + ADDR_W'(i * VLENB + b));
        begin
            int bad;
            bad = 0;
            for (int r = 0; r < 32; r++)
                for (int b = 0; b < VLENB; b++)
                    if (rf[r][b] !== exp_rf[r][b]) bad++;
            check(bad == 0, {tag, " R1 R3 R4 register contents"}, bad, 0);
        end
        check(n_rsp == ((k_fault >= 0) ? k_fault + 1 : beats), {tag, " R1 R5 request count"},
              n_rsp, (k_fault >= 0) ? k_fault + 1 : beats);
        for (int i = 0; i < n_rsp && i < 16; i++) begin
            check(rsp_addr[i] == base + ADDR_W'(i * VLENB), {tag, " R1 beat address"},
                  rsp_addr[i], base + ADDR_W'(i * VLENB));
            check(rsp_nb[i] == (is_mask ? nb : VLENB), {tag, " R3 request byte count"},
                  rsp_nb[i], is_mask ? nb : VLENB);
        end
        if (k_fault < 0) begin
            check(n_done == 1 && n_fault == 0, {tag, " R6 done pulse"}, n_done, 1);
            check(n_dirty == 1 && n_clr == 1, {tag, " R6 dirty/vstart"}, n_dirty, 1);
        end else begin
            check(n_fault == 1 && n_done == 0, {tag, " R7 R8 fault pulse"}, n_fault, 1);
            check(seen_fault_addr == fault_at, {tag, " R7 fault address"}, seen_fault_addr, fault_at);
            check(n_dirty == (k_fault > 0 ? 1 : 0) && n_clr == n_dirty,
                  {tag, k_fault > 0 ? " R7 side effects" : " R8 no side effects"},
                  n_dirty, k_fault > 0 ? 1 : 0);
        end
        fault_en = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        init_rf();
        repeat (3) @(negedge clk);
        #9;
        check(!busy && !mreq_valid && !wr_en && !done && !fault && !mark_dirty && !clear_vstart,
              "R9 reset state", {busy, mreq_valid, wr_en, done, fault, mark_dirty}, 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #9;
        check(!busy && !mreq_valid, "R9 idle after reset", {busy, mreq_valid}, 0);

        // Directed corner cases.
        run_load(0, 32'h1000, 8, 8, 0,   -1, 0, "whole8");
        run_load(0, 32'h2004, 3, 1, 128, -1, 0, "whole1 R2 vl=max");
        run_load(0, 32'h2004, 6, 1, 0,   -1, 0, "whole1 R2 vl=0");
        run_load(1, 32'h3000, 20, 1, 0,   -1, 0, "mask R5 vl=0");
        run_load(1, 32'h3100, 21, 1, 1,   -1, 0, "mask vl=1");
        run_load(1, 32'h3200, 22, 1, 9,   -1, 0, "mask R4 vl=9");
        run_load(1, 32'h3300, 23, 1, 8,   -1, 0, "mask vl=8");
        run_load(1, 32'h3400, 24, 1, 128, -1, 0, "mask vl=max");
        run_load(0, 32'h4000, 16, 4, 5,   2,  0, "whole4 fault k=2");
        run_load(0, 32'h5000, 0, 2, 5,    0,  0, "whole2 fault k=0");
        run_load(1, 32'h6000, 25, 1, 40,  0,  0, "mask fault");
        run_load(0, 32'h7000, 12, 4, 0,   -1, 1, "R10 start while busy");

        // Constrained random loads.
        for (int it = 0; it < 60; it++) begin
            bit m;
            int cnt, dreg, vlen, kf;
            logic [ADDR_W-1:0] base;
            m    = ($urandom % 3) == 0;
            cnt  = 1 << ($urandom % 4);
            dreg = m ? int'($urandom % 32) : int'(($urandom % (32 / cnt)) * cnt);
            vlen = int'($urandom % 129);
            base = $urandom & 32'h000F_FFFF;
            kf   = (($urandom % 4) == 0) ? int'($urandom % (m ? 1 : cnt)) : -1;
            if (m && vlen == 0) kf = -1;
            run_load(m, base, dreg, m ? 1 : cnt, vlen, kf, 0, "random R2");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule